// File: doc/BRIEF.md
# Source-Synchronous Receiver Reset Sequencer

This block releases the resets of a source-synchronous deserializing receiver in a fixed order. The receiver consists of a clock generator, a phase aligner and, optionally, an alignment FIFO. The sequencer holds every reset asserted until the clock generator reports lock. It then frees the phase aligner and waits for the aligner to report lock. If the receiver runs with the alignment FIFO, it next drives a FIFO reset pulse of fixed length. Only after that does it raise a ready flag.

Both lock indications arrive asynchronously and pass through multi-flop synchronizers before the control logic uses them. A restart request, or any loss of clock generator lock, sends the sequencer back to the all-reset state so that the whole bring-up runs again. Surrounding logic uses restart as a recovery step after it sees bit errors. A watchdog counter raises a sticky flag when phase lock does not arrive within a set number of cycles.

Top module: `lvds_rx_rst_seq`

## Requirements
- R1: `aligner_rst` stays 1 while the synchronized clock generator lock is 0. With `SYNC_STAGES`=2, `aligner_rst` drops on the third rising edge after `clkgen_lock_a` is first sampled high, provided `restart` is 0.
- R2: `rx_ready` rises only after phase lock has been observed. In the path without the FIFO stage, it rises on the edge that sees the synchronized phase lock high.
- R3: FIFO mode is selected by `fifo_mode`=1 when phase lock is seen. In this mode `fifo_rst` goes to 1 for exactly `FIFO_PULSE` cycles while `aligner_rst` is 0. `fifo_rst` then returns to 0 on the same edge on which `rx_ready` becomes 1.
- R4: With `fifo_mode`=0 at phase lock, the FIFO stage is skipped: `fifo_rst` stays 0 from the release of `aligner_rst` onwards, and `rx_ready` follows directly.
- R5: `restart`=1 sampled at a rising edge puts the outputs into the all-reset state on that edge: `aligner_rst`=1, `fifo_rst`=1, `rx_ready`=0, `lock_timeout`=0. The outputs stay there while `restart` is held. When `restart` drops, the sequence runs again.
- R6: When the synchronized clock generator lock falls, the sequencer returns to the all-reset state on the next edge, whatever stage it is in.
- R7: `lock_timeout` becomes 1 once the sequencer has spent `LOCK_TIMEOUT` consecutive cycles in the phase-wait stage without phase lock. It stays 1 until the all-reset state is entered again.
- R8: While `rst`=1 the outputs are `aligner_rst`=1, `fifo_rst`=1, `rx_ready`=0, `lock_timeout`=0.
- R9: The phase lock input is synchronized like the clock generator lock. Phase lock raised at the input is acted on no earlier than the third rising edge after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver core clock |
| rst | input | 1 | Synchronous active-high reset |
| clkgen_lock_a | input | 1 | Asynchronous clock generator lock |
| phase_lock_a | input | 1 | Asynchronous phase aligner lock |
| fifo_mode | input | 1 | 1 selects the FIFO-reset stage |
| restart | input | 1 | Request to rerun the whole sequence |
| aligner_rst | output | 1 | Phase aligner reset, active high |
| fifo_rst | output | 1 | Alignment FIFO reset, active high |
| rx_ready | output | 1 | Receiver declared ready |
| lock_timeout | output | 1 | Sticky flag: phase lock did not arrive in time |

## Verification
The bench builds the sequencer with `FIFO_PULSE`=5 and `LOCK_TIMEOUT`=24, keeping the default two-stage synchronizers. The non-default pulse length shows that the FIFO reset width follows the parameter and is not a fixed constant. The short timeout brings the watchdog flag, and the way the flag survives a later lock, within a few dozen cycles. With these values the bench can also drop clock generator lock during the middle of the FIFO pulse as well as in the ready state, and compare every output against a behavioural model on every clock.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD       = 2'd0,
    ST_WAIT_PHASE = 2'd1,
    ST_FIFO_PULSE = 2'd2,
    ST_READY      = 2'd3
  } seq_state_e;

endpackage

// File: rtl/rxseq_sync.sv
module rxseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/rxseq_cnt.sv
module rxseq_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic at_last
);

  localparam int WIDTH = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear)           count <= '0;
    else if (en && count != LAST) count <= count + 1'b1;
  end

  assign at_last = (count == LAST);

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
  import rxseq_pkg::*;
#(
  parameter int FIFO_PULSE   = 4,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_ok,
  input  logic phase_ok,
  input  logic fifo_mode,
  input  logic restart,
  output logic aligner_rst,
  output logic fifo_rst,
  output logic rx_ready,
  output logic lock_timeout
);

  seq_state_e state, state_nxt;
  logic       wait_last, pulse_last;
  logic       timeout_nxt;

  rxseq_cnt #(.LIMIT(LOCK_TIMEOUT)) wait_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (state != ST_WAIT_PHASE),
    .en      (state == ST_WAIT_PHASE),
    .at_last (wait_last)
  );

  rxseq_cnt #(.LIMIT(FIFO_PULSE)) pulse_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (state != ST_FIFO_PULSE),
    .en      (state == ST_FIFO_PULSE),
    .at_last (pulse_last)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_HOLD:       state_nxt = ST_WAIT_PHASE;
      ST_WAIT_PHASE: if (phase_ok) state_nxt = fifo_mode ? ST_FIFO_PULSE : ST_READY;
      ST_FIFO_PULSE: if (pulse_last) state_nxt = ST_READY;
      ST_READY:      state_nxt = ST_READY;
      default:       state_nxt = ST_HOLD;
    endcase
    if (!pll_ok || restart) state_nxt = ST_HOLD;
  end

  always_comb begin
    timeout_nxt = lock_timeout;
    if (state_nxt == ST_HOLD)
      timeout_nxt = 1'b0;
    else if (state == ST_WAIT_PHASE && state_nxt == ST_WAIT_PHASE && wait_last)
      timeout_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HOLD;
      aligner_rst  <= 1'b1;
      fifo_rst     <= 1'b1;
      rx_ready     <= 1'b0;
      lock_timeout <= 1'b0;
    end else begin
      state        <= state_nxt;
      aligner_rst  <= (state_nxt == ST_HOLD);
      fifo_rst     <= (state_nxt == ST_HOLD) || (state_nxt == ST_FIFO_PULSE);
      rx_ready     <= (state_nxt == ST_READY);
      lock_timeout <= timeout_nxt;
    end
  end

endmodule

// File: rtl/lvds_rx_rst_seq.sv
module lvds_rx_rst_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int FIFO_PULSE   = 4,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clkgen_lock_a,
  input  logic phase_lock_a,
  input  logic fifo_mode,
  input  logic restart,
  output logic aligner_rst,
  output logic fifo_rst,
  output logic rx_ready,
  output logic lock_timeout
);

  localparam int NUM_LOCKS = 2;

  logic [NUM_LOCKS-1:0] lock_async;
  logic [NUM_LOCKS-1:0] lock_sync;
  logic                 pll_ok;
  logic                 phase_ok;

  assign lock_async = {phase_lock_a, clkgen_lock_a};

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_sync
    rxseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst      (rst),
      .async_in (lock_async[g]),
      .sync_out (lock_sync[g])
    );
  end

  assign pll_ok   = lock_sync[0];
  assign phase_ok = lock_sync[1];

  rxseq_fsm #(
    .FIFO_PULSE   (FIFO_PULSE),
    .LOCK_TIMEOUT (LOCK_TIMEOUT)
  ) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .pll_ok       (pll_ok),
    .phase_ok     (phase_ok),
    .fifo_mode    (fifo_mode),
    .restart      (restart),
    .aligner_rst  (aligner_rst),
    .fifo_rst     (fifo_rst),
    .rx_ready     (rx_ready),
    .lock_timeout (lock_timeout)
  );

endmodule

// File: rtl/lvds_rx_rst_seq_chk.sv
module lvds_rx_rst_seq_chk #(
  parameter int FIFO_PULSE = 4
) (
  input logic clk,
  input logic rst,
  input logic pll_ok,
  input logic phase_ok,
  input logic restart,
  input logic aligner_rst,
  input logic fifo_rst,
  input logic rx_ready,
  input logic lock_timeout
);

  int unsigned pulse_run;

  always_ff @(posedge clk) begin
    if (rst)                        pulse_run <= 0;
    else if (fifo_rst && !aligner_rst) pulse_run <= pulse_run + 1;
    else                            pulse_run <= 0;
  end

  // R1, R6: lost or missing clock generator lock forces all resets
  p_pll_loss_r6: assert property (@(posedge clk) disable iff (rst)
    !pll_ok |=> (aligner_rst && fifo_rst && !rx_ready));

  // R2: ready without the FIFO stage only follows observed phase lock
  p_ready_lock_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_ready) && !$past(fifo_rst)) |-> $past(phase_ok));

  // R3: a completed FIFO pulse has exactly the configured width
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!fifo_rst && !aligner_rst && pulse_run != 0) |-> (pulse_run == FIFO_PULSE));

  // R5: restart returns everything to reset on the next edge
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (aligner_rst && fifo_rst && !rx_ready && !lock_timeout));

  // R7: the timeout flag only exists outside the all-reset state
  p_timeout_r7: assert property (@(posedge clk) disable iff (rst)
    lock_timeout |-> !aligner_rst);

endmodule

bind lvds_rx_rst_seq lvds_rx_rst_seq_chk #(.FIFO_PULSE(FIFO_PULSE)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pll_ok       (pll_ok),
  .phase_ok     (phase_ok),
  .restart      (restart),
  .aligner_rst  (aligner_rst),
  .fifo_rst     (fifo_rst),
  .rx_ready     (rx_ready),
  .lock_timeout (lock_timeout)
);

// File: tb/lvds_rx_rst_seq_tb_top.sv
`timescale 1ns/1ps
module lvds_rx_rst_seq_tb_top;

  localparam int FP = 5;
  localparam int LT = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkgen_lock_a = 1'b0;
  logic phase_lock_a = 1'b0;
  logic fifo_mode = 1'b0;
  logic restart = 1'b0;
  logic aligner_rst, fifo_rst, rx_ready, lock_timeout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit model_live = 1'b0;

  always #5 clk = ~clk;

  lvds_rx_rst_seq #(
    .SYNC_STAGES  (2),
    .FIFO_PULSE   (FP),
    .LOCK_TIMEOUT (LT)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .clkgen_lock_a(clkgen_lock_a),
    .phase_lock_a (phase_lock_a),
    .fifo_mode    (fifo_mode),
    .restart      (restart),
    .aligner_rst  (aligner_rst),
    .fifo_rst     (fifo_rst),
    .rx_ready     (rx_ready),
    .lock_timeout (lock_timeout)
  );

  // behavioural reference: stage 0 all reset, 1 phase wait, 2 fifo pulse, 3 ready
  int m_stage = 0;
  int m_wait = 0;
  int m_pulse = 0;
  bit m_to = 1'b0;
  bit m_pll_q[$];
  bit m_ph_q[$];
  bit e_arst = 1'b1, e_frst = 1'b1, e_rdy = 1'b0, e_to = 1'b0;

  always @(posedge clk) begin
    int nst;
    bit pll_seen, ph_seen;
    model_live = 1'b1;
    if (rst) begin
      m_pll_q = '{1'b0, 1'b0};
      m_ph_q  = '{1'b0, 1'b0};
      m_stage = 0; m_wait = 0; m_pulse = 0; m_to = 1'b0;
    end else begin
      pll_seen = m_pll_q[0];
      ph_seen  = m_ph_q[0];
      nst = m_stage;
      if (m_stage == 0) nst = 1;
      else if (m_stage == 1 && ph_seen) nst = fifo_mode ? 2 : 3;
      else if (m_stage == 2 && m_pulse == FP - 1) nst = 3;
      if (!pll_seen || restart) nst = 0;
      if (nst == 0) m_to = 1'b0;
      else if (m_stage == 1 && nst == 1 && m_wait == LT - 1) m_to = 1'b1;
      m_wait  = (m_stage == 1) ? ((m_wait < LT - 1) ? m_wait + 1 : m_wait) : 0;
      m_pulse = (m_stage == 2) ? ((m_pulse < FP - 1) ? m_pulse + 1 : m_pulse) : 0;
      m_stage = nst;
      void'(m_pll_q.pop_front());
      void'(m_ph_q.pop_front());
      m_pll_q.push_back(clkgen_lock_a);
      m_ph_q.push_back(phase_lock_a);
    end
    e_arst = (m_stage == 0);
    e_frst = (m_stage == 0) || (m_stage == 2);
    e_rdy  = (m_stage == 3);
    e_to   = m_to;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_live && !done) begin
      check(aligner_rst === e_arst, "R1 model aligner_rst", int'(aligner_rst), int'(e_arst));
      check(fifo_rst === e_frst, "R3 model fifo_rst", int'(fifo_rst), int'(e_frst));
      check(rx_ready === e_rdy, "R2 model rx_ready", int'(rx_ready), int'(e_rdy));
      check(lock_timeout === e_to, "R7 model lock_timeout", int'(lock_timeout), int'(e_to));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    tick(3);
    // R8: reset outputs
    check(aligner_rst && fifo_rst && !rx_ready && !lock_timeout, "R8 reset state",
          {aligner_rst, fifo_rst, rx_ready, lock_timeout}, 4'b1100);
    rst = 1'b0;
    tick(4);
    check(aligner_rst == 1'b1, "R1 held without lock", int'(aligner_rst), 1);

    // R1: release three edges after lock sampled
    clkgen_lock_a = 1'b1;
    tick(2);
    check(aligner_rst == 1'b1, "R1 still held", int'(aligner_rst), 1);
    tick(1);
    check(aligner_rst == 1'b0, "R1 released", int'(aligner_rst), 0);
    tick(3);
    check(rx_ready == 1'b0, "R2 no ready before phase lock", int'(rx_ready), 0);

    // R9, R4: non-FIFO path
    phase_lock_a = 1'b1;
    tick(2);
    check(rx_ready == 1'b0, "R9 phase lock synchronized", int'(rx_ready), 0);
    tick(1);
    check(rx_ready == 1'b1, "R4 ready direct", int'(rx_ready), 1);
    check(fifo_rst == 1'b0, "R4 fifo stage skipped", int'(fifo_rst), 0);

    // R5: restart
    restart = 1'b1;
    tick(1);
    check(aligner_rst && fifo_rst && !rx_ready, "R5 restart all reset",
          {aligner_rst, fifo_rst, rx_ready}, 3'b110);
    tick(3);
    check(aligner_rst == 1'b1, "R5 held while restart", int'(aligner_rst), 1);
    fifo_mode = 1'b1;
    restart = 1'b0;
    tick(1);
    check(aligner_rst == 1'b0, "R5 sequence reruns", int'(aligner_rst), 0);

    // R3: FIFO pulse width
    n = 0;
    for (int i = 0; i < 50; i++) begin
      if (fifo_rst && !aligner_rst) n++;
      if (rx_ready) break;
      tick(1);
    end
    check(n == FP, "R3 fifo pulse width", n, FP);
    check(rx_ready && !fifo_rst, "R3 ready after pulse", {rx_ready, fifo_rst}, 2'b10);

    // R6: lock loss from ready
    clkgen_lock_a = 1'b0;
    tick(2);
    check(rx_ready == 1'b1, "R6 loss not yet seen", int'(rx_ready), 1);
    tick(1);
    check(aligner_rst && !rx_ready, "R6 loss resets", {aligner_rst, rx_ready}, 2'b10);

    // R6: lock loss during FIFO pulse
    clkgen_lock_a = 1'b1;
    tick(6);
    check(fifo_rst && !aligner_rst, "R3 pulse in progress", {fifo_rst, aligner_rst}, 2'b10);
    clkgen_lock_a = 1'b0;
    tick(3);
    check(aligner_rst && fifo_rst, "R6 loss during pulse", {aligner_rst, fifo_rst}, 2'b11);

    // R7: timeout
    phase_lock_a = 1'b0;
    fifo_mode = 1'b0;
    tick(3);
    clkgen_lock_a = 1'b1;
    tick(3 + LT);
    check(lock_timeout == 1'b1, "R7 timeout raised", int'(lock_timeout), 1);
    check(rx_ready == 1'b0, "R2 no ready on timeout", int'(rx_ready), 0);
    phase_lock_a = 1'b1;
    tick(4);
    check(rx_ready && lock_timeout, "R7 flag sticky past lock", {rx_ready, lock_timeout}, 2'b11);
    restart = 1'b1;
    tick(1);
    check(lock_timeout == 1'b0, "R7 cleared on restart", int'(lock_timeout), 0);
    restart = 1'b0;
    tick(10);
    finish_run();
  end

endmodule